// File: doc/BRIEF.md
# Sequential Stage Control Decoder

This block is the control decoder of a processor that runs one instruction per clock. It looks at the two fields of the leading instruction byte (an operation code and a function code) and the two register fields of the register byte. From these it produces every steering signal the datapath needs for that cycle, in the order the instruction is worked through: fetch, decode, execute, memory, write-back and PC update. These signals are the two register-file read selects, the two register-file write selects, the ALU operand sources, the ALU operation, the flag-update enable, the memory read and write strobes with their address source, and the PC hold. It contains no storage. The register file, flags and PC sit in the datapath and load their new values on the rising clock edge.

The decoder handles five instructions: no-operation, halt, register-register arithmetic/logic, store of a register to memory at base-plus-displacement, and stack pop. A pop writes two registers in one cycle: the incremented stack pointer and the loaded value. For that reason the decoder drives separate destination selects for the ALU result and for the memory result. Register ID 8 means "no register" on every select. Any other encoding is flagged as illegal and the decoder makes it side-effect free. A parameter picks whether the function code of a non-arithmetic instruction must be zero.

Top module: `stage_ctl_decoder`

## Requirements
- R1: With operation code 6 and function code 0 to 3, the read selects are A = reg_x and B = reg_y. Operand A comes from read port A (sel 0) and operand B from read port B. The ALU function equals the function code (0 add, 1 subtract, 2 and, 3 xor). The flag update is enabled, the ALU-result destination is reg_y, the memory-result destination is 8, memory stays idle and the PC advances.
- R2: With operation code 4, the read selects are A = reg_x and B = reg_y. Operand A is the constant word (sel 1) and operand B is read port B. The ALU adds, memory writes with the address taken from the ALU result (addr_from_a = 0), both destinations are 8, flags are unchanged and the PC advances.
- R3: With operation code 11, both read selects are register 4 (the stack pointer). Operand A is the constant four (sel 2) and operand B is read port B. The ALU adds, memory reads with the address taken from read port A (addr_from_a = 1), and reg_y has no effect.
- R4: With operation code 11, the ALU-result destination is register 4 and the memory-result destination is reg_x, both in the same cycle.
- R5: When both destinations would name the same register other than 8, the memory-result destination keeps it and the ALU-result destination becomes 8.
- R6: With operation code 0, all four selects are 8, memory and flags are idle, the PC advances and halted is 0.
- R7: With operation code 1, pc_hold and halted are 1 and everything else is idle.
- R8: Any operation code other than 0, 1, 4, 6 and 11 raises illegal and pc_hold, with all selects 8 and no memory access or flag update.
- R9: Operation code 6 with a function code of 4 to 15 is illegal, as in R8.
- R10: With STRICT_FN = 1, a function code other than 0 on codes 0, 1, 4 and 11 is illegal. With STRICT_FN = 0 the function code is ignored on those codes.
- R11: Memory read and write are never active together, and the flag update is only ever active for operation code 6.
- R12: Register ID 8 in reg_x or reg_y passes straight to the selects that take that field, so an arithmetic instruction with reg_y = 8 writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation code of the instruction byte |
| op_fn | input | 4 | Function code of the instruction byte |
| reg_x | input | 4 | First register field |
| reg_y | input | 4 | Second register field |
| rd_sel_a | output | 4 | Register-file read port A select |
| rd_sel_b | output | 4 | Register-file read port B select |
| wr_sel_alu | output | 4 | Destination for the ALU result |
| wr_sel_mem | output | 4 | Destination for the memory result |
| opnd_a_sel | output | 2 | ALU operand A source: 0 port A, 1 constant word, 2 constant four |
| opnd_b_use | output | 1 | 1: ALU operand B is read port B; 0: zero |
| alu_op | output | 2 | 0 add, 1 subtract, 2 and, 3 xor |
| flags_we | output | 1 | Load the condition flags this cycle |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write of read port A value |
| addr_from_a | output | 1 | 1: address is read port A value; 0: ALU result |
| pc_hold | output | 1 | 1: PC keeps its value; 0: PC takes next sequential address |
| halted | output | 1 | Halt instruction present |
| illegal | output | 1 | Encoding not recognised |

## Verification
The bench builds two copies of the decoder. One uses STRICT_FN = 1 and the other STRICT_FN = 0, with the stack pointer at ID 4 and "no register" at ID 8 in both. Feeding the same encodings to both copies brings the two legality variants within reach side by side. It also covers the pop case where the loaded register collides with the stack pointer, and the ID-8 pass-through on every register field.

// File: rtl/stage_ctl_pkg.sv
// Shared encodings for the sequential stage control decoder.
// Assumes 4-bit operation and function codes in the leading instruction byte.
package stage_ctl_pkg;

    localparam int CODE_W = 4;
    localparam int FN_W   = 4;

    localparam logic [CODE_W-1:0] OPC_NOP   = 4'h0;
    localparam logic [CODE_W-1:0] OPC_HALT  = 4'h1;
    localparam logic [CODE_W-1:0] OPC_STORE = 4'h4;
    localparam logic [CODE_W-1:0] OPC_ARITH = 4'h6;
    localparam logic [CODE_W-1:0] OPC_POP   = 4'hB;

    // highest function code accepted on an arithmetic instruction
    localparam logic [FN_W-1:0] ARITH_FN_MAX = 4'h3;

    typedef enum logic [2:0] {
        CL_NOP   = 3'd0,
        CL_HALT  = 3'd1,
        CL_ARITH = 3'd2,
        CL_STORE = 3'd3,
        CL_POP   = 3'd4,
        CL_BAD   = 3'd5
    } insn_class_e;

    typedef enum logic [1:0] {
        OPA_PORT  = 2'd0,
        OPA_CONST = 2'd1,
        OPA_FOUR  = 2'd2
    } opnd_a_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_XOR = 2'd3
    } alu_op_e;

endpackage

// File: rtl/insn_classify.sv
// Sorts the leading instruction byte into one instruction class.
// Assumes: STRICT_FN selects whether non-arithmetic codes need a zero function code.
module insn_classify
    import stage_ctl_pkg::*;
#(
    parameter bit STRICT_FN = 1'b1
) (
    input  logic [CODE_W-1:0] op_code,
    input  logic [FN_W-1:0]   op_fn,
    output insn_class_e       cls
);

    logic fn_ok_other;  // function code acceptable on a non-arithmetic code
    logic fn_ok_arith;  // function code within the ALU range

    // legality variant for the function code on non-arithmetic codes
    generate
        if (STRICT_FN) begin : g_strict
            assign fn_ok_other = (op_fn == '0);
        end else begin : g_lenient
            assign fn_ok_other = 1'b1;
        end
    endgenerate

    assign fn_ok_arith = (op_fn <= ARITH_FN_MAX);

    // map operation code to class, illegal on any unknown value
    always_comb begin
        cls = CL_BAD;
        unique case (op_code)
            OPC_NOP:   cls = fn_ok_other ? CL_NOP   : CL_BAD;
            OPC_HALT:  cls = fn_ok_other ? CL_HALT  : CL_BAD;
            OPC_STORE: cls = fn_ok_other ? CL_STORE : CL_BAD;
            OPC_POP:   cls = fn_ok_other ? CL_POP   : CL_BAD;
            OPC_ARITH: cls = fn_ok_arith ? CL_ARITH : CL_BAD;
            default:   cls = CL_BAD;
        endcase
    end

    // R9: an out-of-range ALU function never yields the arithmetic class
    always_comb begin
        p_arith_fn_range_r9: assert (!(cls == CL_ARITH && op_fn > ARITH_FN_MAX))
            else $error("arithmetic class with function code %0d", op_fn);
    end

endmodule

// File: rtl/reg_port_sel.sv
// Chooses the register-file read and write selects for the decode and
// write-back steps. Assumes NONE_ID disables a port and SP_ID is the stack
// pointer; on a destination clash the memory-result port keeps the register.
module reg_port_sel
    import stage_ctl_pkg::*;
#(
    parameter int RID_W   = 4,
    parameter int SP_ID   = 4,
    parameter int NONE_ID = 8
) (
    input  insn_class_e      cls,
    input  logic [RID_W-1:0] reg_x,
    input  logic [RID_W-1:0] reg_y,
    output logic [RID_W-1:0] rd_sel_a,
    output logic [RID_W-1:0] rd_sel_b,
    output logic [RID_W-1:0] wr_sel_alu,
    output logic [RID_W-1:0] wr_sel_mem
);

    localparam logic [RID_W-1:0] SP_SEL   = RID_W'(SP_ID);
    localparam logic [RID_W-1:0] NONE_SEL = RID_W'(NONE_ID);

    logic [RID_W-1:0] alu_dst_raw;  // ALU-result destination before clash rule

    // read selects for the decode step
    always_comb begin
        rd_sel_a = NONE_SEL;
        rd_sel_b = NONE_SEL;
        case (cls)
            CL_ARITH, CL_STORE: begin
                rd_sel_a = reg_x;
                rd_sel_b = reg_y;
            end
            CL_POP: begin
                rd_sel_a = SP_SEL;
                rd_sel_b = SP_SEL;
            end
            default: ;
        endcase
    end

    // write selects for the write-back step, before the clash rule
    always_comb begin
        alu_dst_raw = NONE_SEL;
        wr_sel_mem  = NONE_SEL;
        case (cls)
            CL_ARITH: alu_dst_raw = reg_y;
            CL_POP: begin
                alu_dst_raw = SP_SEL;
                wr_sel_mem  = reg_x;
            end
            default: ;
        endcase
    end

    // clash rule: the memory-result port keeps a shared destination
    always_comb begin
        wr_sel_alu = alu_dst_raw;
        if (wr_sel_mem != NONE_SEL && alu_dst_raw == wr_sel_mem)
            wr_sel_alu = NONE_SEL;
    end

    // R5: the two write ports never name the same real register
    always_comb begin
        p_dst_distinct_r5: assert (wr_sel_alu == NONE_SEL || wr_sel_alu != wr_sel_mem)
            else $error("both write ports select register %0d", wr_sel_alu);
    end

    // R3: a pop reads the stack pointer on both ports regardless of the fields
    always_comb begin
        p_pop_reads_sp_r3: assert (cls != CL_POP || (rd_sel_a == SP_SEL && rd_sel_b == SP_SEL))
            else $error("pop read selects %0d %0d", rd_sel_a, rd_sel_b);
    end

endmodule

// File: rtl/exec_mem_sel.sv
// Produces execute, memory and PC-update controls from the instruction class.
// Assumes only the low two function bits reach the ALU after legality checks.
module exec_mem_sel
    import stage_ctl_pkg::*;
(
    input  insn_class_e cls,
    input  logic [1:0]  fn_lo,
    output opnd_a_e     opnd_a_sel,
    output logic        opnd_b_use,
    output alu_op_e     alu_op,
    output logic        flags_we,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        addr_from_a,
    output logic        pc_hold,
    output logic        halted,
    output logic        illegal
);

    // execute-step controls: operand sources, ALU operation, flag update
    always_comb begin
        opnd_a_sel = OPA_PORT;
        opnd_b_use = 1'b0;
        alu_op     = ALU_ADD;
        flags_we   = 1'b0;
        case (cls)
            CL_ARITH: begin
                opnd_b_use = 1'b1;
                alu_op     = alu_op_e'(fn_lo);
                flags_we   = 1'b1;
            end
            CL_STORE: begin
                opnd_a_sel = OPA_CONST;
                opnd_b_use = 1'b1;
            end
            CL_POP: begin
                opnd_a_sel = OPA_FOUR;
                opnd_b_use = 1'b1;
            end
            default: ;
        endcase
    end

    // memory-step controls: strobes and address source
    always_comb begin
        mem_rd      = (cls == CL_POP);
        mem_wr      = (cls == CL_STORE);
        addr_from_a = (cls == CL_POP);
    end

    // PC-update and status controls
    always_comb begin
        halted  = (cls == CL_HALT);
        illegal = (cls == CL_BAD);
        pc_hold = (cls == CL_HALT) || (cls == CL_BAD);
    end

    // R11: memory strobes are exclusive
    always_comb begin
        p_mem_exclusive_r11: assert (!(mem_rd && mem_wr))
            else $error("memory read and write together");
    end

    // R8: an illegal encoding touches neither memory nor flags and holds the PC
    always_comb begin
        p_illegal_quiet_r8: assert (!illegal || (pc_hold && !mem_rd && !mem_wr && !flags_we))
            else $error("illegal encoding has side effects");
    end

endmodule

// File: rtl/stage_ctl_decoder.sv
// Top of the sequential stage control decoder: combinational steering for
// one instruction per cycle. Assumes the datapath owns all storage and
// applies writes on the rising clock edge.
module stage_ctl_decoder
    import stage_ctl_pkg::*;
#(
    parameter bit STRICT_FN = 1'b1,
    parameter int RID_W     = 4,
    parameter int SP_ID     = 4,
    parameter int NONE_ID   = 8
) (
    input  logic [3:0]       op_code,
    input  logic [3:0]       op_fn,
    input  logic [RID_W-1:0] reg_x,
    input  logic [RID_W-1:0] reg_y,
    output logic [RID_W-1:0] rd_sel_a,
    output logic [RID_W-1:0] rd_sel_b,
    output logic [RID_W-1:0] wr_sel_alu,
    output logic [RID_W-1:0] wr_sel_mem,
    output logic [1:0]       opnd_a_sel,
    output logic             opnd_b_use,
    output logic [1:0]       alu_op,
    output logic             flags_we,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_from_a,
    output logic             pc_hold,
    output logic             halted,
    output logic             illegal
);

    localparam logic [RID_W-1:0] NONE_SEL = RID_W'(NONE_ID);

    insn_class_e cls;
    opnd_a_e     opnd_a_e_w;
    alu_op_e     alu_op_e_w;

    insn_classify #(.STRICT_FN(STRICT_FN)) u_classify (
        .op_code (op_code),
        .op_fn   (op_fn),
        .cls     (cls)
    );

    reg_port_sel #(.RID_W(RID_W), .SP_ID(SP_ID), .NONE_ID(NONE_ID)) u_ports (
        .cls        (cls),
        .reg_x      (reg_x),
        .reg_y      (reg_y),
        .rd_sel_a   (rd_sel_a),
        .rd_sel_b   (rd_sel_b),
        .wr_sel_alu (wr_sel_alu),
        .wr_sel_mem (wr_sel_mem)
    );

    exec_mem_sel u_exec (
        .cls         (cls),
        .fn_lo       (op_fn[1:0]),
        .opnd_a_sel  (opnd_a_e_w),
        .opnd_b_use  (opnd_b_use),
        .alu_op      (alu_op_e_w),
        .flags_we    (flags_we),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .addr_from_a (addr_from_a),
        .pc_hold     (pc_hold),
        .halted      (halted),
        .illegal     (illegal)
    );

    assign opnd_a_sel = opnd_a_e_w;
    assign alu_op     = alu_op_e_w;

    // R8: an illegal encoding writes no register
    always_comb begin
        p_illegal_no_write_r8: assert (!illegal || (wr_sel_alu == NONE_SEL && wr_sel_mem == NONE_SEL))
            else $error("illegal encoding selects a write");
    end

    // R7: halt always holds the PC
    always_comb begin
        p_halt_holds_pc_r7: assert (!halted || pc_hold)
            else $error("halt without PC hold");
    end

    // R11: flags only move together with an ALU-result destination path
    always_comb begin
        p_flags_no_mem_r11: assert (!flags_we || (!mem_rd && !mem_wr && !illegal))
            else $error("flag update outside arithmetic");
    end

endmodule

// File: tb/stage_ctl_decoder_bench.sv
`timescale 1ns/1ps
module stage_ctl_decoder_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic [3:0] op_code = '0, op_fn = '0, reg_x = '0, reg_y = '0;

    logic [27:0] out_s, out_l;
    logic [3:0] s_ra, s_rb, s_we, s_wm, l_ra, l_rb, l_we, l_wm;
    logic [1:0] s_oa, s_fn, l_oa, l_fn;
    logic s_bu, s_fl, s_mr, s_mw, s_af, s_ph, s_hl, s_il;
    logic l_bu, l_fl, l_mr, l_mw, l_af, l_ph, l_hl, l_il;

    stage_ctl_decoder #(.STRICT_FN(1'b1)) u_stage_ctl_decoder (
        .op_code(op_code), .op_fn(op_fn), .reg_x(reg_x), .reg_y(reg_y),
        .rd_sel_a(s_ra), .rd_sel_b(s_rb), .wr_sel_alu(s_we), .wr_sel_mem(s_wm),
        .opnd_a_sel(s_oa), .opnd_b_use(s_bu), .alu_op(s_fn), .flags_we(s_fl),
        .mem_rd(s_mr), .mem_wr(s_mw), .addr_from_a(s_af), .pc_hold(s_ph),
        .halted(s_hl), .illegal(s_il)
    );

    stage_ctl_decoder #(.STRICT_FN(1'b0)) u_stage_ctl_decoder_lenient (
        .op_code(op_code), .op_fn(op_fn), .reg_x(reg_x), .reg_y(reg_y),
        .rd_sel_a(l_ra), .rd_sel_b(l_rb), .wr_sel_alu(l_we), .wr_sel_mem(l_wm),
        .opnd_a_sel(l_oa), .opnd_b_use(l_bu), .alu_op(l_fn), .flags_we(l_fl),
        .mem_rd(l_mr), .mem_wr(l_mw), .addr_from_a(l_af), .pc_hold(l_ph),
        .halted(l_hl), .illegal(l_il)
    );

    assign out_s = {s_ra, s_rb, s_we, s_wm, s_oa, s_bu, s_fn, s_fl, s_mr, s_mw, s_af, s_ph, s_hl, s_il};
    assign out_l = {l_ra, l_rb, l_we, l_wm, l_oa, l_bu, l_fn, l_fl, l_mr, l_mw, l_af, l_ph, l_hl, l_il};

    int checks = 0;
    int errors = 0;
    int r11_bad = 0;
    bit done = 1'b0;

    // expected outputs from the requirements
    function automatic logic [27:0] expect_out(logic [3:0] c, logic [3:0] f,
                                               logic [3:0] x, logic [3:0] y, bit strict);
        logic [3:0] ra = 4'd8, rb = 4'd8, we = 4'd8, wm = 4'd8;
        logic [1:0] oa = 2'd0, fn = 2'd0;
        logic bu = 0, fl = 0, mr = 0, mw = 0, af = 0, ph = 0, hl = 0, bad = 0;
        bad = !(c == 4'd0 || c == 4'd1 || c == 4'd4 || c == 4'd6 || c == 4'd11);
        if (c == 4'd6 && f > 4'd3) bad = 1;
        if (strict && c != 4'd6 && f != 4'd0) bad = 1;
        if (bad) ph = 1;
        else begin
            case (c)
                4'd1: begin ph = 1; hl = 1; end
                4'd6: begin ra = x; rb = y; bu = 1; fn = f[1:0]; fl = 1; we = y; end
                4'd4: begin ra = x; rb = y; oa = 2'd1; bu = 1; mw = 1; end
                4'd11: begin
                    ra = 4'd4; rb = 4'd4; oa = 2'd2; bu = 1; mr = 1; af = 1;
                    we = 4'd4; wm = x;
                    if (wm != 4'd8 && we == wm) we = 4'd8;
                end
                default: ;
            endcase
        end
        return {ra, rb, we, wm, oa, bu, fn, fl, mr, mw, af, ph, hl, bad};
    endfunction

    function automatic string tag_of(logic [3:0] c, logic [3:0] f, logic [3:0] x, logic [3:0] y);
        if (c == 4'd6) return (f > 4'd3) ? "R9" : ((y == 4'd8) ? "R12" : "R1");
        if (!(c == 4'd0 || c == 4'd1 || c == 4'd4 || c == 4'd11)) return "R8";
        if (f != 4'd0) return "R10";
        if (c == 4'd4) return "R2";
        if (c == 4'd11) return (x == 4'd4) ? "R5" : "R4";
        if (c == 4'd1) return "R7";
        return "R6";
    endfunction

    task automatic apply(logic [3:0] c, logic [3:0] f, logic [3:0] x, logic [3:0] y, string tag);
        logic [27:0] es, el;
        @(posedge clk);
        op_code = c; op_fn = f; reg_x = x; reg_y = y;
        @(negedge clk);
        es = expect_out(c, f, x, y, 1'b1);
        el = expect_out(c, f, x, y, 1'b0);
        checks++;
        if (out_s !== es) begin
            errors++;
            $display("FAIL %s strict code=%0d fn=%0d x=%0d y=%0d actual=%h expected=%h",
                     tag, c, f, x, y, out_s, es);
        end
        checks++;
        if (out_l !== el) begin
            errors++;
            $display("FAIL %s lenient code=%0d fn=%0d x=%0d y=%0d actual=%h expected=%h",
                     tag, c, f, x, y, out_l, el);
        end
        // R11 tracked over every vector
        if ((s_mr && s_mw) || (l_mr && l_mw) || (s_fl && c != 4'd6) || (l_fl && c != 4'd6))
            r11_bad++;
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        // reset-like initial state: all inputs zero is a nop (R6)
        apply(4'd0, 4'd0, 4'd0, 4'd0, "R6");
        for (int f = 0; f < 4; f++) apply(4'd6, 4'(f), 4'd2, 4'd5, "R1");
        apply(4'd6, 4'd7, 4'd1, 4'd3, "R9");
        apply(4'd6, 4'd15, 4'd1, 4'd3, "R9");
        apply(4'd4, 4'd0, 4'd6, 4'd3, "R2");
        apply(4'd11, 4'd0, 4'd3, 4'd9, "R3");
        apply(4'd11, 4'd0, 4'd7, 4'd0, "R4");
        apply(4'd11, 4'd0, 4'd4, 4'd2, "R5");
        apply(4'd11, 4'd0, 4'd8, 4'd8, "R12");
        apply(4'd6, 4'd1, 4'd8, 4'd8, "R12");
        apply(4'd4, 4'd0, 4'd8, 4'd1, "R12");
        apply(4'd1, 4'd0, 4'd3, 4'd3, "R7");
        for (int c = 0; c < 16; c++) apply(4'(c), 4'd0, 4'd1, 4'd2, "R8");
        apply(4'd0, 4'd5, 4'd1, 4'd1, "R10");
        apply(4'd1, 4'd2, 4'd1, 4'd1, "R10");
        apply(4'd11, 4'd1, 4'd3, 4'd1, "R10");
        apply(4'd4, 4'd9, 4'd3, 4'd1, "R10");
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] c, f, x, y;
            c = ($urandom % 3 == 0) ? 4'($urandom) :
                (($urandom % 2 == 0) ? 4'd6 : 4'd11);
            f = ($urandom % 2 == 0) ? 4'($urandom % 4) : 4'($urandom);
            x = 4'($urandom % 10);
            y = 4'($urandom % 10);
            apply(c, f, x, y, tag_of(c, f, x, y));
        end
        checks++;
        if (r11_bad != 0) begin
            errors++;
            $display("FAIL R11 exclusivity violations actual=%0d expected=0", r11_bad);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule